// File: doc/BRIEF.md
# Probe-Burst Least-Queued Sample Picker

This block sits at the receiving end of one direction of a time-transfer exchange. That direction may be master to slave, around the sync message, or slave to master, around the delay request. The far end sends a short burst: first one probe, then the timing message itself, then four more probes. Each arriving entry is given to the block in one cycle, with three fields: the departure timestamp stamped by the sender, the local arrival timestamp, and the entry's position in the burst.

Across the burst, the block compares how far apart the entries arrived with how far apart they were sent. The entry whose arrival spacing grew the least, relative to the first entry, waited the least in queues along the path. Once the burst is complete, the block outputs that entry's departure/arrival pair and its position. The offset calculation downstream then uses this pair in place of the single timing message.

If a burst arrives with a gap or a reordering in its positions, the block drops the burst and raises a one-cycle error pulse instead of a sample. Control is a two-state machine:
- **ST_IDLE** waits for an entry at position 0.
- **ST_COLLECT** accepts positions 1 to 5 in order.

The transitions are:
- **start**: ST_IDLE to ST_COLLECT, on position 0.
- **finish**: ST_COLLECT to ST_IDLE, on position 5.
- **abort**: ST_COLLECT to ST_IDLE, on a wrong nonzero position.
- **restart**: ST_COLLECT to ST_COLLECT, on an unexpected position 0.

Top module: `probe_min_queue_sel`

## Requirements
- R1: After reset, `smp_valid` and `burst_err` are 0, and `smp_dep`, `smp_arr` and `smp_idx` are 0.
- R2: A burst is six entries carrying `msg_seq` 0,1,2,3,4,5 in that order. Position 0 is the leading probe, position 1 is the timing message, and positions 2 to 5 are trailing probes. A sample is produced only for a complete, in-order burst.
- R3: For each entry i, excess(i) = (arr(i) - arr(0)) - (dep(i) - dep(0)). The output sample is the entry with the smallest excess.
- R4: When several entries share the smallest excess, the one with the lowest position is output.
- R5: Excess is a signed quantity, so an entry can win with a negative excess. Timestamp differences are taken modulo 2^TS_W, so a burst whose timestamps wrap through zero is judged correctly.
- R6: `smp_valid` is high for exactly one cycle: the cycle after the clock edge that accepts position 5. In that cycle `smp_dep`, `smp_arr` and `smp_idx` hold the winner's pair and position.
- R7: While collecting, a nonzero position other than the expected one causes a one-cycle `burst_err` pulse in the next cycle and no sample. Further nonzero positions are then ignored until a position 0 arrives.
- R8: A position 0 that arrives mid-burst raises `burst_err` for the broken burst and starts a new burst with that entry as its first.
- R9: While idle, entries with a nonzero position produce neither a sample nor an error.
- R10: Cycles with `msg_valid` low between entries of a burst have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An entry is present this cycle |
| msg_seq | input | IDX_W (3) | Position of the entry in its burst |
| msg_dep | input | TS_W (32) | Departure timestamp from the sender |
| msg_arr | input | TS_W (32) | Local arrival timestamp |
| smp_valid | output | 1 | One-cycle pulse marking a selected sample |
| smp_dep | output | TS_W (32) | Departure timestamp of the selected entry |
| smp_arr | output | TS_W (32) | Arrival timestamp of the selected entry |
| smp_idx | output | IDX_W (3) | Position of the selected entry |
| burst_err | output | 1 | One-cycle pulse marking a discarded burst |

## Verification
Each kind of internal fault shows at the ports in a particular way:
- A stale running minimum or a wrong base pair changes `smp_idx` and the output pair in the single cycle after position 5. The bench makes that visible by giving each burst a unique winner, or a deliberate tie.
- An expected-position counter that is out of step shows as a missing sample, or as a `burst_err` pulse one cycle after the offending entry.
- A state that fails to return to idle shows on the next burst or on a stray entry, as a spurious error or a sample.

The bench therefore checks both pulse outputs in the cycle after every entry that could trigger them, and again one cycle later.

// File: rtl/qsel_pkg.sv
package qsel_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } qsel_state_e;
endpackage

// File: rtl/qsel_excess.sv
// Queuing excess of one entry relative to the first entry of its burst.
module qsel_excess #(
    parameter int TS_W = 32
) (
    input  logic [TS_W-1:0]     dep,
    input  logic [TS_W-1:0]     arr,
    input  logic [TS_W-1:0]     base_dep,
    input  logic [TS_W-1:0]     base_arr,
    output logic signed [TS_W:0] excess
);
    logic [TS_W-1:0] arr_gap;
    logic [TS_W-1:0] dep_gap;

    always_comb begin
        arr_gap = arr - base_arr;
        dep_gap = dep - base_dep;
        excess  = $signed({1'b0, arr_gap}) - $signed({1'b0, dep_gap});
    end
endmodule

// File: rtl/qsel_better.sv
// Strict comparison: equal excess keeps the earlier holder.
module qsel_better #(
    parameter int TS_W = 32
) (
    input  logic signed [TS_W:0] cand,
    input  logic signed [TS_W:0] best,
    output logic                 take
);
    always_comb take = (cand < best);
endmodule

// File: rtl/probe_min_queue_sel.sv
module probe_min_queue_sel
    import qsel_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int BURST = 6,
    parameter int IDX_W = $clog2(BURST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [IDX_W-1:0] msg_seq,
    input  logic [TS_W-1:0]  msg_dep,
    input  logic [TS_W-1:0]  msg_arr,
    output logic             smp_valid,
    output logic [TS_W-1:0]  smp_dep,
    output logic [TS_W-1:0]  smp_arr,
    output logic [IDX_W-1:0] smp_idx,
    output logic             burst_err
);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(BURST - 1);
    localparam logic [IDX_W-1:0] NEXT_POS = IDX_W'(1);

    qsel_state_e state, state_nx;

    logic [IDX_W-1:0]     exp_seq;
    logic [TS_W-1:0]      base_dep, base_arr;
    logic [TS_W-1:0]      best_dep, best_arr;
    logic [IDX_W-1:0]     best_idx;
    logic signed [TS_W:0] best_exc;
    logic signed [TS_W:0] cand_exc;
    logic                 take;

    logic seq_ok, seq_zero, start, accept, broken, finish;

    qsel_excess #(.TS_W(TS_W)) u_excess (
        .dep      (msg_dep),
        .arr      (msg_arr),
        .base_dep (base_dep),
        .base_arr (base_arr),
        .excess   (cand_exc)
    );

    qsel_better #(.TS_W(TS_W)) u_better (
        .cand (cand_exc),
        .best (best_exc),
        .take (take)
    );

    always_comb begin
        seq_ok   = (msg_seq == exp_seq);
        seq_zero = (msg_seq == '0);
        accept   = msg_valid && (state == ST_COLLECT) && seq_ok;
        broken   = msg_valid && (state == ST_COLLECT) && !seq_ok;
        finish   = accept && (exp_seq == LAST_POS);
        start    = msg_valid && seq_zero &&
                   ((state == ST_IDLE) || broken);
    end

    // next-state: start, finish, abort, restart
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (finish)      state_nx = ST_IDLE;
                else if (broken) state_nx = seq_zero ? ST_COLLECT : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // burst bookkeeping: base pair, running minimum, expected position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_seq  <= '0;
            base_dep <= '0;
            base_arr <= '0;
            best_dep <= '0;
            best_arr <= '0;
            best_idx <= '0;
            best_exc <= '0;
        end else if (start) begin
            exp_seq  <= NEXT_POS;
            base_dep <= msg_dep;
            base_arr <= msg_arr;
            best_dep <= msg_dep;
            best_arr <= msg_arr;
            best_idx <= '0;
            best_exc <= '0;
        end else if (accept) begin
            exp_seq <= exp_seq + 1'b1;
            if (take) begin
                best_dep <= msg_dep;
                best_arr <= msg_arr;
                best_idx <= msg_seq;
                best_exc <= cand_exc;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            burst_err <= 1'b0;
            smp_dep   <= '0;
            smp_arr   <= '0;
            smp_idx   <= '0;
        end else begin
            smp_valid <= finish;
            burst_err <= broken;
            if (finish) begin
                smp_dep <= take ? msg_dep : best_dep;
                smp_arr <= take ? msg_arr : best_arr;
                smp_idx <= take ? msg_seq : best_idx;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R6

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ($past(msg_valid) && $past(msg_seq) == LAST_POS)); // R2

    AST_ERR_ONLY_COLLECTING: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err |-> ($past(msg_valid) && $past(state) == ST_COLLECT)); // R7

    AST_NO_SAMPLE_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && burst_err)); // R7

    AST_IDX_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (smp_idx <= LAST_POS)); // R3

    AST_IDLE_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && msg_valid && msg_seq != '0) |=> (state == ST_IDLE && !burst_err)); // R9
endmodule

// File: tb/probe_min_queue_sel_tb.sv
module probe_min_queue_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TS_W  = 32;
    localparam int BURST = 6;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             msg_valid = 1'b0;
    logic [IDX_W-1:0] msg_seq = '0;
    logic [TS_W-1:0]  msg_dep = '0;
    logic [TS_W-1:0]  msg_arr = '0;
    logic             smp_valid;
    logic [TS_W-1:0]  smp_dep;
    logic [TS_W-1:0]  smp_arr;
    logic [IDX_W-1:0] smp_idx;
    logic             burst_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [TS_W-1:0] bd [BURST];
    logic [TS_W-1:0] ba [BURST];

    always #(CLK_PERIOD/2) clk = ~clk;

    probe_min_queue_sel #(.TS_W(TS_W), .BURST(BURST)) u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_seq(msg_seq),
        .msg_dep(msg_dep), .msg_arr(msg_arr), .smp_valid(smp_valid),
        .smp_dep(smp_dep), .smp_arr(smp_arr), .smp_idx(smp_idx),
        .burst_err(burst_err)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // drive one entry for one cycle; returns at the negedge after capture
    task automatic send(input int seq, input logic [TS_W-1:0] d, input logic [TS_W-1:0] a, input int gap);
        @(negedge clk);
        msg_valid = 1'b1;
        msg_seq   = IDX_W'(seq);
        msg_dep   = d;
        msg_arr   = a;
        @(negedge clk);
        msg_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // fill bd/ba: departures spaced 100 from d0, arrival = dep + lat + q[i]
    task automatic fill(input logic [TS_W-1:0] d0, input logic [TS_W-1:0] lat,
                        input int q0, input int q1, input int q2,
                        input int q3, input int q4, input int q5);
        int q [BURST];
        q = '{q0, q1, q2, q3, q4, q5};
        for (int i = 0; i < BURST; i++) begin
            bd[i] = d0 + TS_W'(100 * i);
            ba[i] = bd[i] + lat + TS_W'(q[i]);
        end
    endtask

    function automatic int model_pick();
        longint best;
        int     idx;
        best = 0;
        idx  = 0;
        for (int i = 1; i < BURST; i++) begin
            longint e;
            e = longint'(ba[i] - ba[0]) - longint'(bd[i] - bd[0]);
            if (e < best) begin
                best = e;
                idx  = i;
            end
        end
        return idx;
    endfunction

    task automatic run_burst(input int gap, input string tag);
        int w;
        w = model_pick();
        for (int i = 0; i < BURST; i++) begin
            send(i, bd[i], ba[i], (i == BURST-1) ? 0 : gap);
            if (i < BURST-1) chk(smp_valid, 0, {tag, " no early sample R2"});
        end
        chk(smp_valid, 1, {tag, " valid R6"});
        chk(burst_err, 0, {tag, " no err R6"});
        chk(smp_idx, w, {tag, " idx R3"});
        chk(smp_dep, bd[w], {tag, " dep R6"});
        chk(smp_arr, ba[w], {tag, " arr R6"});
        @(negedge clk);
        chk(smp_valid, 0, {tag, " pulse one cycle R6"});
    endtask

    task automatic t_reset();
        chk(smp_valid, 0, "R1 valid");
        chk(burst_err, 0, "R1 err");
        chk(smp_dep, 0, "R1 dep");
        chk(smp_arr, 0, "R1 arr");
        chk(smp_idx, 0, "R1 idx");
    endtask

    task automatic t_plain();
        fill(32'd1000, 32'd500, 30, 10, 40, 5, 20, 25);
        run_burst(0, "R3 min at 3");
        fill(32'd5000, 32'd700, 0, 0, 0, 0, 0, 0);
        run_burst(0, "R4 all equal");
        fill(32'd9000, 32'd300, 20, 8, 15, 8, 30, 9);
        run_burst(0, "R4 tie 1v3");
    endtask

    task automatic t_negative_wrap();
        fill(32'd200, 32'd50, 400, 100, 350, 300, 120, 90);
        run_burst(0, "R5 negative");
        fill(32'hFFFF_FE00, 32'd600, 50, 60, 70, 45, 12, 33);
        run_burst(0, "R5 wrap");
    endtask

    task automatic t_gaps();
        fill(32'd40000, 32'd123, 7, 9, 2, 11, 3, 8);
        run_burst(3, "R10 gaps");
    endtask

    task automatic t_missing();
        fill(32'd100, 32'd10, 0, 0, 0, 0, 0, 0);
        send(0, bd[0], ba[0], 0);
        send(1, bd[1], ba[1], 0);
        send(3, bd[3], ba[3], 0);
        chk(burst_err, 1, "R7 gap err");
        chk(smp_valid, 0, "R7 gap no sample");
        @(negedge clk);
        chk(burst_err, 0, "R7 err one cycle");
        send(4, bd[4], ba[4], 0);
        chk(burst_err, 0, "R7 rest ignored err");
        send(5, bd[5], ba[5], 0);
        chk(smp_valid, 0, "R7 rest ignored sample");
        chk(burst_err, 0, "R7 rest ignored err2");
        send(0, bd[0], ba[0], 0);
        send(2, bd[2], ba[2], 0);
        chk(burst_err, 1, "R7 reorder err");
        chk(smp_valid, 0, "R7 reorder no sample");
    endtask

    task automatic t_restart();
        fill(32'd70000, 32'd900, 60, 10, 50, 40, 30, 20);
        send(0, 32'd1, 32'd2, 0);
        send(1, 32'd3, 32'd4, 0);
        send(2, 32'd5, 32'd6, 0);
        send(0, bd[0], ba[0], 0);
        chk(burst_err, 1, "R8 restart err");
        chk(smp_valid, 0, "R8 restart no sample");
        for (int i = 1; i < BURST; i++) send(i, bd[i], ba[i], 0);
        chk(smp_valid, 1, "R8 new burst valid");
        chk(smp_idx, model_pick(), "R8 new burst idx");
        chk(smp_arr, ba[model_pick()], "R8 new burst arr");
    endtask

    task automatic t_idle_stray();
        send(4, 32'd11, 32'd22, 0);
        chk(smp_valid, 0, "R9 stray sample");
        chk(burst_err, 0, "R9 stray err");
        send(5, 32'd11, 32'd22, 0);
        chk(smp_valid, 0, "R9 stray last sample");
        chk(burst_err, 0, "R9 stray last err");
        fill(32'd80000, 32'd40, 9, 9, 9, 9, 1, 9);
        run_burst(0, "R9 burst after stray");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_negative_wrap();
        t_gaps();
        t_missing();
        t_restart();
        t_idle_stray();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule